// File: doc/BRIEF.md
# Progressive Composite Video Timing Generator

This block generates the complete timing for a non-interlaced, NTSC-style composite video signal. It runs from a single 16 MHz clock and needs no processor intervention once it is out of reset. A horizontal counter divides time into lines of fixed length. A vertical counter groups those lines into frames. From the two counts the block decides, on every clock, whether the video output sits at sync, black or picture level.

Two digital pins carry the result, and an external resistor network mixes them into an analog level. The control pin is low only while the signal must sit at sync level. The data pin carries a serial pixel stream, one bit per pixel, taken from a parallel word that the block samples once per line. Lines that carry no picture run through the same sequence as picture lines, with zeros loaded in place of the word. Every line therefore has identical timing, whatever its content.

Two one-clock strobes mark the first clock of every line and the first clock of every frame. Surrounding logic uses them to update the pixel word in time.

Top module: `compositeTimingGen`

## Requirements
- R1: A line lasts LINE_CLKS clocks (default 1016, i.e. 63.5 us at 16 MHz). `lineStart` is high for exactly one clock at horizontal position 0 of every line, and the first such clock is the first cycle after reset is released.
- R2: A frame holds FRAME_LINES lines (default 262), with no interlace and no half-lines. `frameStart` is high for exactly one clock, at position 0 of line 0.
- R3: On every line from VSYNC_LINES (default 3) onwards, the pins read sync for positions 0 to HSYNC_CLKS-1 (default 0..74).
- R4: On lines 0 to VSYNC_LINES-1, the pins read sync from position 0 up to LINE_CLKS-HSYNC_CLKS-1 (default 0..940). They read black for the rest of the line.
- R5: On lines outside vertical sync, the pins read black from the end of horizontal sync up to ACTIVE_START-1 (default 75..149). They also read black from ACTIVE_END to the end of the line (default 986..1015).
- R6: Lines VSYNC_LINES to IMAGE_FIRST_LINE-1 (default 3..19) carry no picture. Outside sync they read black for the whole line, whatever value `pixWord` holds.
- R7: On lines IMAGE_FIRST_LINE and later, the data pin shows bit PIX_W-1-i of the word during positions ACTIVE_START+i*PIX_DIV to ACTIVE_START+(i+1)*PIX_DIV-1, for i from 0 to PIX_W-1 (MSB first; default 32 bits, 26 clocks each). Between the last bit and ACTIVE_END the data pin is 0.
- R8: Pin encoding as {vidCtrl, vidData}: 00 = sync, 10 = black, 11 = white, 01 = gray. The data pin is never high while the control pin is low, so this generator never produces code 01.
- R9: Reset is synchronous and active high. While it is asserted the pins read black (10) and both strobes are low. On release, both counters restart from line 0, position 0.
- R10: `pixWord` is sampled only on the clock that ends position ACTIVE_START-1. Any later change within the line has no effect on the data pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel timing clock (16 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| pixWord | input | PIX_W | Parallel pixel word for the current line |
| vidCtrl | output | 1 | Sync/black control pin, low = sync level |
| vidData | output | 1 | Serial pixel pin, high = white while vidCtrl is high |
| lineStart | output | 1 | One-clock strobe at position 0 of every line |
| frameStart | output | 1 | One-clock strobe at position 0 of line 0 |

## Verification
The hardest situation to reach from the ports is the sampling instant of the pixel word. A design that sampled one clock late, or kept following the input, would give the same picture for any input held constant across the line. The bench therefore presents the intended word only up to the sampling clock and then drives its bitwise complement for the rest of the line. It also drives non-zero words on the blank and vertical-sync lines, so that any leak onto the data pin shows up. To keep the sweep short, it runs a reduced line and frame geometry for two full frames and part of a third, which covers every position of every line type. A reset applied in the middle of a frame then checks the restart.

// File: rtl/cvid_pkg.sv
package cvid_pkg;

  // Strobes from the timing control to the pixel datapath
  typedef struct packed {
    logic lineStart;   // position 0 of a line
    logic frameStart;  // position 0 of line 0
    logic syncLvl;     // pins must read sync level
    logic imageLine;   // current line may carry picture
    logic loadWord;    // last clock before the active window
    logic inWindow;    // inside the active window
  } ctrlStrobes_t;

endpackage

// File: rtl/cvid_timing.sv
module cvid_timing
  import cvid_pkg::*;
#(
  parameter int LINE_CLKS        = 1016,
  parameter int FRAME_LINES      = 262,
  parameter int HSYNC_CLKS       = 75,
  parameter int ACTIVE_START     = 150,
  parameter int ACTIVE_END       = 986,
  parameter int VSYNC_LINES      = 3,
  parameter int IMAGE_FIRST_LINE = 20
) (
  input  logic         clk,
  input  logic         rst,
  output ctrlStrobes_t strb
);

  localparam int HW = $clog2(LINE_CLKS);
  localparam int VW = $clog2(FRAME_LINES);
  localparam logic [HW-1:0] H_LAST      = HW'(LINE_CLKS - 1);
  localparam logic [HW-1:0] H_SYNC_END  = HW'(HSYNC_CLKS);
  localparam logic [HW-1:0] H_VSYNC_END = HW'(LINE_CLKS - HSYNC_CLKS);
  localparam logic [HW-1:0] H_ACT_FIRST = HW'(ACTIVE_START);
  localparam logic [HW-1:0] H_ACT_END   = HW'(ACTIVE_END);
  localparam logic [HW-1:0] H_PRELOAD   = HW'(ACTIVE_START - 1);
  localparam logic [VW-1:0] V_LAST      = VW'(FRAME_LINES - 1);
  localparam logic [VW-1:0] V_SYNC_END  = VW'(VSYNC_LINES);
  localparam logic [VW-1:0] V_IMG_FIRST = VW'(IMAGE_FIRST_LINE);

  logic [HW-1:0] hCount;
  logic [VW-1:0] vCount;
  logic          lineEnd;
  logic          vsyncLine;
  logic          syncNow;

  assign lineEnd = (hCount == H_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
      vCount <= '0;
    end else begin
      hCount <= lineEnd ? '0 : hCount + 1'b1;
      if (lineEnd)
        vCount <= (vCount == V_LAST) ? '0 : vCount + 1'b1;
    end
  end

  assign vsyncLine = (vCount < V_SYNC_END);
  assign syncNow   = vsyncLine ? (hCount < H_VSYNC_END) : (hCount < H_SYNC_END);

  always_comb begin
    strb.lineStart  = !rst && (hCount == '0);
    strb.frameStart = !rst && (hCount == '0) && (vCount == '0);
    strb.syncLvl    = !rst && syncNow;
    strb.imageLine  = (vCount >= V_IMG_FIRST);
    strb.loadWord   = !rst && (hCount == H_PRELOAD);
    strb.inWindow   = !rst && (hCount >= H_ACT_FIRST) && (hCount < H_ACT_END);
  end

endmodule

// File: rtl/cvid_pixel.sv
module cvid_pixel
  import cvid_pkg::*;
#(
  parameter int PIX_W   = 32,
  parameter int PIX_DIV = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strb,
  input  logic [PIX_W-1:0] pixWord,
  output logic             vidCtrl,
  output logic             vidData
);

  localparam int PDW = (PIX_DIV > 2) ? $clog2(PIX_DIV) : 1;
  localparam logic [PDW-1:0] PHASE_LAST = PDW'(PIX_DIV - 1);

  logic [PIX_W-1:0] shiftReg;
  logic [PDW-1:0]   phase;

  // Blank lines load zeros so every line runs the same shift sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      phase    <= '0;
    end else if (strb.loadWord) begin
      shiftReg <= strb.imageLine ? pixWord : '0;
      phase    <= '0;
    end else if (strb.inWindow) begin
      if (phase == PHASE_LAST) begin
        phase    <= '0;
        shiftReg <= {shiftReg[PIX_W-2:0], 1'b0};
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign vidCtrl = !strb.syncLvl;
  assign vidData = strb.inWindow && !strb.syncLvl && shiftReg[PIX_W-1];

endmodule

// File: rtl/compositeTimingGen.sv
module compositeTimingGen
  import cvid_pkg::*;
#(
  parameter int LINE_CLKS        = 1016,
  parameter int FRAME_LINES      = 262,
  parameter int HSYNC_CLKS       = 75,
  parameter int ACTIVE_START     = 150,
  parameter int ACTIVE_END       = 986,
  parameter int VSYNC_LINES      = 3,
  parameter int IMAGE_FIRST_LINE = 20,
  parameter int PIX_W            = 32,
  parameter int PIX_DIV          = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pixWord,
  output logic             vidCtrl,
  output logic             vidData,
  output logic             lineStart,
  output logic             frameStart
);

  ctrlStrobes_t strb;

  cvid_timing #(
    .LINE_CLKS       (LINE_CLKS),
    .FRAME_LINES     (FRAME_LINES),
    .HSYNC_CLKS      (HSYNC_CLKS),
    .ACTIVE_START    (ACTIVE_START),
    .ACTIVE_END      (ACTIVE_END),
    .VSYNC_LINES     (VSYNC_LINES),
    .IMAGE_FIRST_LINE(IMAGE_FIRST_LINE)
  ) uTiming (
    .clk (clk),
    .rst (rst),
    .strb(strb)
  );

  cvid_pixel #(
    .PIX_W  (PIX_W),
    .PIX_DIV(PIX_DIV)
  ) uPixel (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .pixWord(pixWord),
    .vidCtrl(vidCtrl),
    .vidData(vidData)
  );

  assign lineStart  = strb.lineStart;
  assign frameStart = strb.frameStart;

endmodule

// File: rtl/cvid_checker.sv
module cvid_checker (
  input logic clk,
  input logic rst,
  input logic vidCtrl,
  input logic vidData,
  input logic lineStart,
  input logic frameStart
);

  assert_line_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
    lineStart |=> !lineStart);

  assert_frame_on_line_R2: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> lineStart);

  assert_sync_at_line_start_R3: assert property (@(posedge clk) disable iff (rst)
    lineStart |-> !vidCtrl);

  assert_no_gray_code_R8: assert property (@(posedge clk) disable iff (rst)
    !(!vidCtrl && vidData));

  assert_reset_black_R9: assert property (@(posedge clk)
    rst |-> (vidCtrl && !vidData && !lineStart && !frameStart));

endmodule

bind compositeTimingGen cvid_checker uChk (.*);

// File: tb/tb_compositeTimingGen.sv
module tb_compositeTimingGen;

  localparam int LC  = 120;
  localparam int FL  = 30;
  localparam int HS  = 10;
  localparam int AS  = 20;
  localparam int AE  = 118;
  localparam int VSL = 3;
  localparam int IFL = 6;
  localparam int PW  = 8;
  localparam int PD  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] pixWord = '0;
  logic vidCtrl, vidData, lineStart, frameStart;

  int vectors = 0;
  int errors  = 0;
  int h = 0;
  int v = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  compositeTimingGen #(
    .LINE_CLKS(LC), .FRAME_LINES(FL), .HSYNC_CLKS(HS), .ACTIVE_START(AS),
    .ACTIVE_END(AE), .VSYNC_LINES(VSL), .IMAGE_FIRST_LINE(IFL),
    .PIX_W(PW), .PIX_DIV(PD)
  ) dut (
    .clk(clk), .rst(rst), .pixWord(pixWord), .vidCtrl(vidCtrl),
    .vidData(vidData), .lineStart(lineStart), .frameStart(frameStart)
  );

  function automatic logic [PW-1:0] goodWord(int line);
    return PW'(line * 37 + 90);
  endfunction

  task automatic checkBit(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s line=%0d pos=%0d actual=%b expected=%b", req, v, h, act, exp);
    end
  endtask

  task automatic checkAll();
    bit syncE;
    logic dataE;
    string ctrlReq;
    string dataReq;
    syncE = (v < VSL) ? (h < LC - HS) : (h < HS);
    dataE = 1'b0;
    if (v >= IFL && h >= AS && h < AS + PW * PD) begin
      logic [PW-1:0] w;
      w = goodWord(v);
      dataE = w[PW - 1 - (h - AS) / PD];
    end
    if (v < VSL) ctrlReq = "R4";
    else if (h < HS) ctrlReq = "R3";
    else if (v < IFL) ctrlReq = "R6";
    else ctrlReq = "R5";
    if (v < VSL) dataReq = "R4";
    else if (v < IFL) dataReq = "R6";
    else dataReq = "R7/R10";
    checkBit(ctrlReq, vidCtrl, !syncE);
    checkBit(dataReq, vidData, dataE);
    checkBit("R1", lineStart, h == 0);
    checkBit("R2", frameStart, (h == 0) && (v == 0));
    checkBit("R8", !vidCtrl && vidData, 1'b0);
  endtask

  task automatic runCycles(int n);
    for (int k = 0; k < n; k++) begin
      #1;
      checkAll();
      // intended word only up to the sampling clock, complement after (R10)
      pixWord = (h < AS) ? goodWord(v) : ~goodWord(v);
      @(negedge clk);
      if (h == LC - 1) begin
        h = 0;
        v = (v == FL - 1) ? 0 : v + 1;
      end else begin
        h = h + 1;
      end
    end
  endtask

  task automatic checkReset();
    #1;
    checkBit("R9", vidCtrl, 1'b1);
    checkBit("R9", vidData, 1'b0);
    checkBit("R9", lineStart, 1'b0);
    checkBit("R9", frameStart, 1'b0);
  endtask

  initial begin
    pixWord = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkReset();
    rst = 1'b0;
    h = 0;
    v = 0;
    runCycles(2 * LC * FL + 5 * LC + 37);
    // reset in mid-frame, then restart from line 0 position 0 (R9)
    rst = 1'b1;
    checkReset();
    @(negedge clk);
    checkReset();
    @(negedge clk);
    checkReset();
    rst = 1'b0;
    h = 0;
    v = 0;
    runCycles(10 * LC);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog (all) actual=expired expected=completed");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule